// File: doc/BRIEF.md
# Cascadable Magnitude Comparator with Operand Latch

This block compares two words, P and Q, and drives two decoded results: P greater than Q and P less than Q. There is no equality output. A mode input picks how the words are read: unsigned binary, or two's complement. The word width is a parameter and defaults to 8 bits.

Stages can be chained to compare longer words. Each stage takes the two results of the stage that handles the next less significant slice. When its own slice of P equals its own slice of Q, a stage passes those results through unchanged. When the slices differ, the stage ignores them and decides on its own.

In a chain, the least significant stage has both cascade inputs tied low. Only the most significant stage uses two's complement mode; all lower stages use unsigned mode. If both outputs at the top of the chain are low, the full words are equal.

P reaches the comparison through a level-sensitive latch. While the latch enable is high, the latch is open and P flows through. While the enable is low, the latch holds the last P value. Q is never latched, so one operand can be held while the other changes.

Top module: `magcmp_cascade`

## Requirements
- R1: With `arith` = 0, `gt_o` is 1 exactly when the effective P is greater than Q read as unsigned numbers, and `lt_o` is 1 exactly when it is smaller (provided the words differ).
- R2: With `arith` = 1, the same decisions are made reading both words as two's complement numbers. Bit W-1 is the sign bit.
- R3: When the effective P and Q differ, exactly one of `gt_o`, `lt_o` is 1, and the cascade inputs have no effect on either output.
- R4: When the effective P equals Q, `gt_o` equals `casc_gt_i` and `lt_o` equals `casc_lt_i`. This includes the invalid case where both cascade inputs are 1, which is passed through unchanged.
- R5: While `p_open` = 1, the effective P equals `p_word`, so the outputs follow changes on `p_word` with no clock.
- R6: While `p_open` = 0, the effective P keeps the value `p_word` had when `p_open` last fell. Changes on `p_word` have no effect on the outputs.
- R7: `q_word` always feeds the comparison directly, including while P is held.
- R8: Four stages can be chained as follows: stage k compares bits 8k+7..8k; stage 0 has both cascade inputs tied to 0; each stage feeds its outputs to the cascade inputs of stage k+1; only stage 3 has `arith` = 1 for a signed compare. Such a chain compares 32-bit words correctly. Both top outputs at 0 mean the words are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| p_word | input | W | P operand, before the latch |
| p_open | input | 1 | Latch enable for P: 1 = transparent, 0 = hold |
| q_word | input | W | Q operand, never latched |
| arith | input | 1 | 1 = two's complement compare, 0 = unsigned compare |
| casc_gt_i | input | 1 | P>Q result from the less significant stage |
| casc_lt_i | input | 1 | P<Q result from the less significant stage |
| gt_o | output | 1 | P greater than Q |
| lt_o | output | 1 | P less than Q |

## Verification
The assertions are immediate checks on combinational values, so they rely on the inputs being settled, two-state values when they are evaluated. The bench changes inputs only between sampling points and waits before it samples. The local-decision assertions make no assumption about the cascade inputs: the both-high combination is driven on purpose and must pass through. The stimulus keeps to the chaining rule, with the lowest stage tied low and only the top stage in two's complement mode, so that the wide results can be predicted from the 32-bit operands.

// File: rtl/magcmp_pkg.sv
package magcmp_pkg;
  typedef enum logic {
    CMP_UNSIGNED = 1'b0,
    CMP_SIGNED   = 1'b1
  } cmp_mode_e;

  typedef struct packed {
    logic gt;
    logic lt;
  } cmp_res_t;
endpackage

// File: rtl/opnd_latch.sv
module opnd_latch #(
  parameter int W = 8
) (
  input  logic         open_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] hold_q;

  always_latch begin
    if (open_i) hold_q <= d_i;
  end

  assign q_o = hold_q;
endmodule

// File: rtl/word_relation.sv
module word_relation
  import magcmp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  cmp_mode_e    mode_i,
  output cmp_res_t     rel_o
);
  localparam int MSB = W - 1;

  logic [W-1:0] a_key;
  logic [W-1:0] b_key;

  // signed order maps onto unsigned order by inverting the sign bit
  always_comb begin
    a_key = a_i;
    b_key = b_i;
    if (mode_i == CMP_SIGNED) begin
      a_key[MSB] = ~a_i[MSB];
      b_key[MSB] = ~b_i[MSB];
    end
  end

  // bit-serial scan from MSB: first differing bit decides
  logic [W:0] dec_gt;
  logic [W:0] dec_lt;
  assign dec_gt[W] = 1'b0;
  assign dec_lt[W] = 1'b0;

  for (genvar i = W - 1; i >= 0; i--) begin : g_scan
    assign dec_gt[i] = dec_gt[i+1] | (~dec_lt[i+1] & a_key[i] & ~b_key[i]);
    assign dec_lt[i] = dec_lt[i+1] | (~dec_gt[i+1] & ~a_key[i] & b_key[i]);
  end

  assign rel_o.gt = dec_gt[0];
  assign rel_o.lt = dec_lt[0];

  always_comb begin
    p_excl_rel_r3: assert (!(rel_o.gt && rel_o.lt))
      else $error("local decision asserted both directions");
  end
endmodule

// File: rtl/cascade_merge.sv
module cascade_merge
  import magcmp_pkg::*;
(
  input  cmp_res_t local_i,
  input  cmp_res_t chain_i,
  output cmp_res_t res_o
);
  logic local_same;
  assign local_same = ~(local_i.gt | local_i.lt);

  always_comb begin
    if (local_same) res_o = chain_i;
    else            res_o = local_i;
  end

  always_comb begin
    if (!local_same) begin
      p_onehot_diff_r3: assert ($countones({res_o.gt, res_o.lt}) == 1)
        else $error("differing words must give exactly one result");
    end else begin
      p_pass_eq_r4: assert (res_o == chain_i)
        else $error("equal words must pass cascade results");
    end
  end
endmodule

// File: rtl/magcmp_cascade.sv
module magcmp_cascade
  import magcmp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] p_word,
  input  logic         p_open,
  input  logic [W-1:0] q_word,
  input  logic         arith,
  input  logic         casc_gt_i,
  input  logic         casc_lt_i,
  output logic         gt_o,
  output logic         lt_o
);
  logic [W-1:0] p_eff;
  cmp_mode_e    mode;
  cmp_res_t     local_rel;
  cmp_res_t     chain_rel;
  cmp_res_t     final_rel;

  assign mode      = arith ? CMP_SIGNED : CMP_UNSIGNED;
  assign chain_rel = '{gt: casc_gt_i, lt: casc_lt_i};

  opnd_latch #(.W(W)) u_plat (
    .open_i (p_open),
    .d_i    (p_word),
    .q_o    (p_eff)
  );

  word_relation #(.W(W)) u_rel (
    .a_i    (p_eff),
    .b_i    (q_word),
    .mode_i (mode),
    .rel_o  (local_rel)
  );

  cascade_merge u_merge (
    .local_i (local_rel),
    .chain_i (chain_rel),
    .res_o   (final_rel)
  );

  assign gt_o = final_rel.gt;
  assign lt_o = final_rel.lt;

  always_comb begin
    if (p_open) begin
      p_open_follow_r5: assert ((p_eff == q_word) == (p_word == q_word))
        else $error("open latch must present p_word");
    end
    if (p_eff == q_word) begin
      p_eq_out_r4: assert (gt_o == casc_gt_i && lt_o == casc_lt_i)
        else $error("equal words must echo cascade inputs");
    end
  end
endmodule

// File: tb/magcmp_cascade_test.sv
`timescale 1ns/1ps
module magcmp_cascade_test;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [W-1:0] p_word, q_word;
  logic p_open, arith, cgt, clt, gt_o, lt_o;

  magcmp_cascade #(.W(W)) uut (
    .p_word(p_word), .p_open(p_open), .q_word(q_word), .arith(arith),
    .casc_gt_i(cgt), .casc_lt_i(clt), .gt_o(gt_o), .lt_o(lt_o)
  );

  // four-stage chain for 32-bit words
  logic [31:0] wp, wq;
  logic        warith;
  logic [4:0]  cg, cl;
  assign cg[0] = 1'b0;
  assign cl[0] = 1'b0;
  for (genvar k = 0; k < 4; k++) begin : g_chain
    magcmp_cascade #(.W(8)) stage (
      .p_word(wp[8*k +: 8]), .p_open(1'b1), .q_word(wq[8*k +: 8]),
      .arith((k == 3) ? warith : 1'b0),
      .casc_gt_i(cg[k]), .casc_lt_i(cl[k]),
      .gt_o(cg[k+1]), .lt_o(cl[k+1])
    );
  end

  task automatic check(input string req, input logic [1:0] got, input logic [1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got gt,lt=%b expected=%b", req, got, exp);
    end
  endtask

  function automatic logic [1:0] ref8(input logic [7:0] a, input logic [7:0] b,
                                      input logic sg, input logic [1:0] cin);
    if (a == b) return cin;
    if (sg) return ($signed(a) > $signed(b)) ? 2'b10 : 2'b01;
    return (a > b) ? 2'b10 : 2'b01;
  endfunction

  function automatic logic [1:0] ref32(input logic [31:0] a, input logic [31:0] b,
                                       input logic sg);
    if (a == b) return 2'b00;
    if (sg) return ($signed(a) > $signed(b)) ? 2'b10 : 2'b01;
    return (a > b) ? 2'b10 : 2'b01;
  endfunction

  task automatic wide(input logic [31:0] a, input logic [31:0] b, input logic sg);
    wp = a; wq = b; warith = sg;
    #2;
    check("R8", {cg[4], cl[4]}, ref32(a, b, sg));
  endtask

  initial begin
    p_word = '0; q_word = '0; p_open = 1'b1; arith = 1'b0; cgt = 1'b0; clt = 1'b0;
    wp = '0; wq = '0; warith = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R4", {gt_o, lt_o}, 2'b00);

    // exhaustive single-stage sweep, both modes (R1, R2, R3)
    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b++) begin
          arith = m[0]; p_word = a[7:0]; q_word = b[7:0];
          cgt = a[0]; clt = b[1];
          #1;
          if (a == b) check("R4", {gt_o, lt_o}, {cgt, clt});
          else if (m == 1) check("R2", {gt_o, lt_o}, ref8(a[7:0], b[7:0], 1'b1, 2'b00));
          else check("R1", {gt_o, lt_o}, ref8(a[7:0], b[7:0], 1'b0, 2'b00));
        end
      end
    end

    // cascade ignored when different (R3), passed when equal incl. both high (R4)
    arith = 1'b0; p_word = 8'd9; q_word = 8'd3;
    for (int c = 0; c < 4; c++) begin
      cgt = c[1]; clt = c[0]; #1;
      check("R3", {gt_o, lt_o}, 2'b10);
    end
    q_word = 8'd9;
    for (int c = 0; c < 4; c++) begin
      cgt = c[1]; clt = c[0]; #1;
      check("R4", {gt_o, lt_o}, c[1:0]);
    end

    // latch behaviour (R5, R6, R7)
    cgt = 1'b0; clt = 1'b0; arith = 1'b0;
    p_open = 1'b1; p_word = 8'd5; q_word = 8'd5; #1;
    check("R5", {gt_o, lt_o}, 2'b00);
    p_word = 8'd6; #1;
    check("R5", {gt_o, lt_o}, 2'b10);
    p_word = 8'd5; #1;
    p_open = 1'b0; #1;
    for (int v = 0; v < 256; v += 17) begin
      p_word = v[7:0]; #1;
      check("R6", {gt_o, lt_o}, 2'b00);
    end
    q_word = 8'd6; #1;
    check("R7", {gt_o, lt_o}, 2'b01);
    q_word = 8'd4; #1;
    check("R7", {gt_o, lt_o}, 2'b10);
    p_word = 8'd200; p_open = 1'b1; #1;
    check("R5", {gt_o, lt_o}, 2'b10);
    p_open = 1'b0; p_word = 8'd1; #1;
    check("R6", {gt_o, lt_o}, 2'b10);
    p_open = 1'b1;

    // 32-bit chain corners and random (R8)
    for (int m = 0; m < 2; m++) begin
      wide(32'h1234_5678, 32'h1234_5678, m[0]);
      wide(32'h8000_0000, 32'h7FFF_FFFF, m[0]);
      wide(32'h7FFF_FFFF, 32'h8000_0000, m[0]);
      wide(32'h8000_0000, 32'h8000_0001, m[0]);
      wide(32'hA5A5_A501, 32'hA5A5_A500, m[0]);
      wide(32'hA5A5_A500, 32'hA5A5_A501, m[0]);
      wide(32'h0000_0000, 32'hFFFF_FFFF, m[0]);
      wide(32'hFFFF_FFFF, 32'hFFFF_FFFF, m[0]);
      for (int i = 0; i < 400; i++) begin
        logic [31:0] ra, rb;
        ra = $urandom; rb = $urandom;
        if (i % 4 == 0) rb = {ra[31:8], rb[7:0]};
        if (i % 4 == 1) rb = {ra[31:16], rb[15:0]};
        wide(ra, rb, m[0]);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired got=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule